// File: doc/BRIEF.md
# Triggered One-Shot Waveform Timer

This block produces a single two-phase pulse. Firmware starts it through a start bit in an output control register, or an edge on an external trigger pin starts it. Once armed, the output holds the active level for a programmed primary length and then the idle level for a secondary length. When the secondary phase runs out, hardware clears the start bit by itself. A level-latch bit sets which logic level counts as active. An output-select bit can replace the waveform with a static bit taken from a port data register.

Software reaches two 8-bit registers through a small write/read port. At address 0 is the output control register: bit 0 is the start bit and bit 1 is the output select. At address 1 is the trigger control register: bit 0 enables the trigger, bit 1 selects the polarity and bit 2 is the level latch. The trigger pin passes through a two-flop synchronizer. After that, an edge detector looks for one edge or for both, depending on how the pin is configured. The count-enable input must stay high for the pulse to continue.

Top module: `oneshot_wave_timer`

## Requirements
- R1: After reset, both registers read 0x00, the start bit is 0 and `wave_out` is 0.
- R2: A write of 1 to address 0 bit 0 while idle with `count_en`=1 starts the one-shot. The start bit then reads 1. The same write while `count_en`=0 is ignored.
- R3: A start registered at edge k makes `wave_out` active from edge k+1 for `pri_len`+1 cycles and then idle for `sec_len`+1 cycles. At the last of those idle cycles the start bit clears by itself.
- R4: A write of 1 to the start bit in the cycle the count completes does not re-arm the one-shot. The completion clear wins.
- R5: A write of 0 to address 0 bit 0 during a pulse stops it. The start bit reads 0 and the output returns to idle.
- R6: If `count_en` is low during a pulse, the start bit is forced to 0.
- R7: With address 1 bit 0 = 0, edges on `trig_pin` never start the one-shot.
- R8: With the trigger enabled and `single_edge`=1, address 1 bit 1 selects the active edge: 0 for falling, 1 for rising. With `single_edge`=0, either edge starts the one-shot and the polarity bit is not used.
- R9: Address 1 bit 2 = 0 gives idle low and active high. A value of 1 inverts both levels.
- R10: With address 0 bit 1 = 1 and `pgm_mode`=1, `wave_out` follows `port_bit` one cycle later. With `pgm_mode`=0 the select bit has no effect.
- R11: Reserved bits read as 0 and writes to them are ignored. Address 0 uses bits 7:2, address 1 uses bits 7:3, and unmapped addresses read 0x00.
- R12: A trigger-pin change sampled at edge k sets the start bit at edge k+2. A trigger edge that arrives while a pulse runs is ignored and does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| count_en | input | 1 | Count enable; low stops a running pulse |
| pgm_mode | input | 1 | Programmable waveform mode active |
| single_edge | input | 1 | Trigger pin in single-edge detection mode |
| trig_pin | input | 1 | Asynchronous external trigger |
| port_bit | input | 1 | Port data register bit used as static output |
| pri_len | input | CNT_W | Primary (active) phase length minus one |
| sec_len | input | CNT_W | Secondary (idle) phase length minus one |
| wave_out | output | 1 | Registered waveform output |

## Verification
Firmware starts are tried with phase lengths long enough to be stopped partway and short enough to complete. A write of 1 is landed exactly on the completion cycle, which separates a correct completion priority from a re-arm. Trigger edges of both directions are applied under each combination of enable, polarity and edge mode, which shows whether the gate and the edge selection are decoded separately. Extra edges during a running pulse show whether the pulse restarts. The level latch, the port select in and out of programmable mode, and all-ones writes to the reserved bits show that the output mux and the register masks are independent.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int REG_W       = 8;
  localparam int OUTCTL_ADDR = 0;
  localparam int TRGCTL_ADDR = 1;
  localparam int B_START     = 0;
  localparam int B_OSEL      = 1;
  localparam int B_TEN       = 0;
  localparam int B_POL       = 1;
  localparam int B_LVL       = 2;

  typedef enum logic {PH_ACTIVE = 1'b0, PH_IDLE = 1'b1} phase_t;
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic single_edge,
  input  logic rise_sel,
  output logic edge_hit
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hist_q;
  logic cur, prv, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[HIST_W-2:0], pin};
  end

  assign cur  = hist_q[SYNC_STAGES-1];
  assign prv  = hist_q[SYNC_STAGES];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    if (single_edge) edge_hit = rise_sel ? rise : fall;
    else             edge_hit = rise | fall;
  end
endmodule

// File: rtl/ost_counter.sv
module ost_counter
  import ost_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen,
  input  logic             launch,
  input  logic             stop_req,
  input  logic [CNT_W-1:0] pri_len,
  input  logic [CNT_W-1:0] sec_len,
  output logic             running,
  output logic             in_active,
  output logic             done
);
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign running   = run_q;
  assign in_active = run_q & (phase_q == PH_ACTIVE);
  assign done      = run_q & cen & (phase_q == PH_IDLE) & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= PH_ACTIVE;
      cnt_q   <= '0;
    end else if (run_q) begin
      if (!cen || stop_req) begin
        run_q <= 1'b0;
      end else if (phase_q == PH_ACTIVE) begin
        if (at_zero) begin
          phase_q <= PH_IDLE;
          cnt_q   <= sec_len;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (at_zero) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (launch) begin
      run_q   <= 1'b1;
      phase_q <= PH_ACTIVE;
      cnt_q   <= pri_len;
    end
  end
endmodule

// File: rtl/ost_out_stage.sv
module ost_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic pulse_on,
  input  logic level_inv,
  input  logic use_port,
  input  logic port_bit,
  output logic wave_q
);
  always_ff @(posedge clk) begin
    if (rst)           wave_q <= 1'b0;
    else if (use_port) wave_q <= port_bit;
    else               wave_q <= pulse_on ^ level_inv;
  end
endmodule

// File: rtl/oneshot_wave_timer.sv
module oneshot_wave_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 count_en,
  input  logic                 pgm_mode,
  input  logic                 single_edge,
  input  logic                 trig_pin,
  input  logic                 port_bit,
  input  logic [CNT_W-1:0]     pri_len,
  input  logic [CNT_W-1:0]     sec_len,
  output logic                 wave_out
);
  logic osel_q, ten_q, pol_q, lvl_q;
  logic wr_out, wr_trg, fw_start, stop_req, launch;
  logic edge_hit, running, in_active, done;
  logic [REG_W-1:0] rd_nxt;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:3];

  assign wr_out   = reg_we & (reg_addr == ADDR_W'(OUTCTL_ADDR));
  assign wr_trg   = reg_we & (reg_addr == ADDR_W'(TRGCTL_ADDR));
  assign fw_start = wr_out & reg_wdata[B_START];
  assign stop_req = wr_out & ~reg_wdata[B_START];
  assign launch   = ~running & count_en & (fw_start | (ten_q & edge_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      osel_q <= 1'b0;
      ten_q  <= 1'b0;
      pol_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (wr_out) osel_q <= reg_wdata[B_OSEL];
      if (wr_trg) begin
        ten_q <= reg_wdata[B_TEN];
        pol_q <= reg_wdata[B_POL];
        lvl_q <= reg_wdata[B_LVL];
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (reg_addr == ADDR_W'(OUTCTL_ADDR)) begin
      rd_nxt[B_START] = running;
      rd_nxt[B_OSEL]  = osel_q;
    end else if (reg_addr == ADDR_W'(TRGCTL_ADDR)) begin
      rd_nxt[B_TEN] = ten_q;
      rd_nxt[B_POL] = pol_q;
      rd_nxt[B_LVL] = lvl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  ost_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .single_edge(single_edge),
    .rise_sel(pol_q), .edge_hit(edge_hit)
  );

  ost_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cen(count_en), .launch(launch),
    .stop_req(stop_req), .pri_len(pri_len), .sec_len(sec_len),
    .running(running), .in_active(in_active), .done(done)
  );

  ost_out_stage u_out (
    .clk(clk), .rst(rst), .pulse_on(in_active), .level_inv(lvl_q),
    .use_port(pgm_mode & osel_q), .port_bit(port_bit), .wave_q(wave_out)
  );
endmodule

// File: rtl/ost_checker.sv
module ost_checker (
  input logic       clk,
  input logic       rst,
  input logic       running,
  input logic       done,
  input logic       cen,
  input logic       fw_start,
  input logic       stop_req,
  input logic       pgm_mode,
  input logic       osel,
  input logic       port_bit,
  input logic       wave_out,
  input logic [7:0] reg_rdata
);
  p_done_clears_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !running);

  p_done_beats_write_r4: assert property (@(posedge clk) disable iff (rst)
    (done && fw_start) |=> !running);

  p_stop_write_r5: assert property (@(posedge clk) disable iff (rst)
    (running && stop_req) |=> !running);

  p_cen_low_stops_r6: assert property (@(posedge clk) disable iff (rst)
    (running && !cen) |=> !running);

  p_port_follow_r10: assert property (@(posedge clk) disable iff (rst)
    $past(pgm_mode && osel) |-> (wave_out == $past(port_bit)));

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:3] == 5'b0);

  p_no_retrigger_r12: assert property (@(posedge clk) disable iff (rst)
    (running && cen && !done && !stop_req) |=> running);
endmodule

bind oneshot_wave_timer ost_checker u_chk (
  .clk(clk), .rst(rst), .running(running), .done(done), .cen(count_en),
  .fw_start(fw_start), .stop_req(stop_req), .pgm_mode(pgm_mode),
  .osel(osel_q), .port_bit(port_bit), .wave_out(wave_out),
  .reg_rdata(reg_rdata)
);

// File: tb/oneshot_wave_timer_tb.sv
module oneshot_wave_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       count_en = 1'b1;
  logic       pgm_mode = 1'b0;
  logic       single_edge = 1'b1;
  logic       trig_pin = 1'b0;
  logic       port_bit = 1'b0;
  logic [7:0] pri_len = 8'd3;
  logic [7:0] sec_len = 8'd2;
  logic       wave_out;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit started = 0;

  always #10 clk = ~clk;

  oneshot_wave_timer u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_en(count_en),
    .pgm_mode(pgm_mode), .single_edge(single_edge), .trig_pin(trig_pin),
    .port_bit(port_bit), .pri_len(pri_len), .sec_len(sec_len),
    .wave_out(wave_out)
  );

  // behavioural reference model
  bit m_run, m_act, m_osel, m_ten, m_pol, m_lvl, m_wave;
  bit m_s1, m_s2, m_s3;
  int m_cnt;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit edge_seen, wr0, wr1;
    started = 1;
    if (rst) begin
      m_run = 0; m_act = 0; m_osel = 0; m_ten = 0; m_pol = 0; m_lvl = 0;
      m_wave = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_rd = 8'h00;
    end else begin
      if (single_edge) edge_seen = m_pol ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
      else             edge_seen = (m_s2 != m_s3);
      wr0 = reg_we && reg_addr == 2'd0;
      wr1 = reg_we && reg_addr == 2'd1;
      m_wave = (pgm_mode && m_osel) ? port_bit : ((m_run && m_act) ^ m_lvl);
      case (reg_addr)
        2'd0:    m_rd = {6'b0, m_osel, m_run};
        2'd1:    m_rd = {5'b0, m_lvl, m_pol, m_ten};
        default: m_rd = 8'h00;
      endcase
      if (m_run) begin
        if (!count_en || (wr0 && !reg_wdata[0])) m_run = 0;
        else if (m_cnt > 0) m_cnt--;
        else if (m_act) begin m_act = 0; m_cnt = int'(sec_len); end
        else m_run = 0;
      end else if (count_en && ((wr0 && reg_wdata[0]) || (m_ten && edge_seen))) begin
        m_run = 1; m_act = 1; m_cnt = int'(pri_len);
      end
      if (wr0) m_osel = reg_wdata[1];
      if (wr1) begin m_ten = reg_wdata[0]; m_pol = reg_wdata[1]; m_lvl = reg_wdata[2]; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_pin;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (wave_out !== m_wave || reg_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s model: wave=%b rdata=%h expected wave=%b rdata=%h",
                 cur_req, wave_out, reg_rdata, m_wave, m_rd);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
    end
    reg_addr = 2'd0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    chk_bit(wave_out, 1'b0, "R1 wave");

    cur_req = "R2";
    wr(2'd0, 8'h01);
    cycles(1);
    chk_bit(wave_out, 1'b1, "R3 active level");
    rd(2'd0, 8'h01, "R2");
    cur_req = "R3";
    cycles(12);
    chk_bit(wave_out, 1'b0, "R3 idle after pulse");
    rd(2'd0, 8'h00, "R3");

    cur_req = "R4";
    wr(2'd0, 8'h01);
    cycles(6);
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h00, "R4");
    cycles(2);
    chk_bit(wave_out, 1'b0, "R4 no re-arm");

    cur_req = "R5";
    pri_len = 8'd20;
    wr(2'd0, 8'h01);
    cycles(4);
    wr(2'd0, 8'h00);
    cycles(1);
    chk_bit(wave_out, 1'b0, "R5 stopped");
    rd(2'd0, 8'h00, "R5");

    cur_req = "R6";
    wr(2'd0, 8'h01);
    cycles(3);
    count_en = 1'b0;
    cycles(1);
    count_en = 1'b1;
    rd(2'd0, 8'h00, "R6");
    count_en = 1'b0;
    wr(2'd0, 8'h01);
    count_en = 1'b1;
    rd(2'd0, 8'h00, "R2 start ignored with count disabled");
    pri_len = 8'd3;

    cur_req = "R7";
    trig_pin = 1'b1;
    cycles(5);
    rd(2'd0, 8'h00, "R7");
    trig_pin = 1'b0;
    cycles(5);
    rd(2'd0, 8'h00, "R7");

    cur_req = "R8";
    wr(2'd1, 8'h03);
    trig_pin = 1'b1;
    cycles(3);
    chk_bit(reg_rdata[0], 1'b0, "R12 latency before");
    cycles(1);
    chk_bit(reg_rdata[0], 1'b1, "R12 latency start");
    cycles(12);
    trig_pin = 1'b0;
    cycles(6);
    rd(2'd0, 8'h00, "R8 falling ignored");
    wr(2'd1, 8'h01);
    trig_pin = 1'b1;
    cycles(6);
    rd(2'd0, 8'h00, "R8 rising ignored");
    trig_pin = 1'b0;
    cycles(5);
    rd(2'd0, 8'h01, "R8 falling starts");
    cycles(12);
    single_edge = 1'b0;
    wr(2'd1, 8'h03);
    trig_pin = 1'b1;
    cycles(5);
    rd(2'd0, 8'h01, "R8 both-edge rise");
    cycles(12);
    trig_pin = 1'b0;
    cycles(5);
    rd(2'd0, 8'h01, "R8 both-edge fall");
    cycles(12);

    cur_req = "R12";
    trig_pin = 1'b1;
    cycles(3);
    trig_pin = 1'b0;
    cycles(6);
    rd(2'd0, 8'h01, "R12 still running");
    rd(2'd0, 8'h00, "R12 no extension");
    single_edge = 1'b1;
    wr(2'd1, 8'h00);

    cur_req = "R9";
    wr(2'd1, 8'h04);
    cycles(1);
    chk_bit(wave_out, 1'b1, "R9 idle high");
    wr(2'd0, 8'h01);
    cycles(1);
    chk_bit(wave_out, 1'b0, "R9 active low");
    cycles(12);
    chk_bit(wave_out, 1'b1, "R9 idle high after");

    cur_req = "R10";
    pgm_mode = 1'b1;
    port_bit = 1'b0;
    wr(2'd0, 8'h02);
    cycles(2);
    chk_bit(wave_out, 1'b0, "R10 port 0");
    port_bit = 1'b1;
    cycles(2);
    chk_bit(wave_out, 1'b1, "R10 port 1");
    port_bit = 1'b0;
    pgm_mode = 1'b0;
    cycles(2);
    chk_bit(wave_out, 1'b1, "R10 select ignored outside mode");
    rd(2'd0, 8'h02, "R10");

    cur_req = "R11";
    wr(2'd1, 8'hF8);
    rd(2'd1, 8'h00, "R11");
    wr(2'd0, 8'hFC);
    rd(2'd0, 8'h00, "R11");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h00, "R11");
    rd(2'd0, 8'h00, "R11");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h07, "R11");
    wr(2'd1, 8'h00);
    cycles(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule